// File: doc/BRIEF.md
# Interrupt Recognition and Polling Unit

This unit sits beside the instruction sequencer of a small 8-bit processor core and decides, each time an instruction retires, whether the next thing the core does is an interrupt entry instead of the next opcode fetch. When it starts an entry, it also says which kind of entry. It watches a reset request, a level-sensitive maskable request line, an edge-triggered non-maskable request line and the interrupt-disable flag. The sequencer tells it three more things: when an instruction boundary occurs, which flag-changing instruction class just retired, and which cycle of a software break sequence is in progress.

Two behaviour sets are supported, and a `cmos_mode` input picks one. The older set (`cmos_mode` = 0) has two effects. A maskable request that is unmasked by a clear-disable or a flag pull waits one more instruction, and a non-maskable request that arrives early in a software break redirects that break to the non-maskable vector. The newer set (`cmos_mode` = 1) recognises the unmasked request at once. It holds a non-maskable request that arrives during a break and services it afterwards. The decision is registered and reaches the outputs one clock after the boundary strobe. The vector redirect flag is held until the break sequence ends.

Top module: `irq_poll_unit`

## Requirements
- R1: At a boundary (`boundary` = 1) the priority is reset, then non-maskable, then maskable. One clock later `take_int` = 1 and `kind` gives the winner: 1 = reset, 2 = non-maskable, 3 = maskable. With no winner, `take_int` = 0 and `kind` = 0. `take_int` is never 1 unless `boundary` was 1 on the clock before.
- R2: A `reset_req` pulse is remembered until a boundary services it as a reset entry.
- R3: The maskable request (`irq_n` = 0, level-sensitive) is taken only when the effective mask is clear. When the retiring class is "other" (`op_class` = 0), the effective mask is the `i_flag` value present at that boundary.
- R4: A falling edge of `nmi_n` is latched. The latch is cleared by the entry that services it, so a line held low causes exactly one non-maskable entry.
- R5: Older set: when a clear-disable (`op_class` = 1) retires with the flag set before it, the maskable request is not taken at that boundary. It is taken at the boundary of the next instruction.
- R6: Older set: if a set-disable (`op_class` = 2) retires right after such an unmasking instruction, the waiting maskable request is not taken at all.
- R7: Two clear-disable instructions in a row act as one, and the maskable request is taken at the boundary of the second.
- R8: A flag pull (`op_class` = 3) that clears the flag follows the same rules as R5 to R7: the one-instruction wait, cancellation by a following set-disable, and a repeated pull acting as one.
- R9: Newer set: a clear-disable or flag pull that clears the flag lets the maskable request be taken at its own boundary.
- R10: In both sets, a set-disable that retires while the flag was clear before it still lets a pending maskable request be taken at its boundary.
- R11: Older set: a non-maskable request seen while `brk_cycle` is 1 to 5 sets `vec_nmi` on the next clock and consumes the request. `vec_nmi` stays set until `brk_cycle` returns to 0. A request seen at cycle 6 or later stays pending for the next boundary.
- R12: Newer set: `vec_nmi` never rises. A non-maskable request that arrives during a break is taken at the first boundary after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmos_mode | input | 1 | 1 selects the newer behaviour set |
| reset_req | input | 1 | Reset entry request |
| nmi_n | input | 1 | Non-maskable request, active on falling edge |
| irq_n | input | 1 | Maskable request, active low level |
| i_flag | input | 1 | Interrupt-disable flag after the retiring instruction |
| boundary | input | 1 | Instruction boundary strobe |
| op_class | input | 2 | Retiring instruction: 0 other, 1 clear-disable, 2 set-disable, 3 flag pull |
| brk_cycle | input | 3 | Break sequence cycle, 0 when no break is running |
| take_int | output | 1 | Start an interrupt entry (registered) |
| kind | output | 2 | Entry kind: 0 none, 1 reset, 2 non-maskable, 3 maskable |
| vec_nmi | output | 1 | Break must fetch the non-maskable vector |

## Verification
The bench targets the mask-timing cases. A design that polls with the new flag value would take the request on the clear-disable itself in the older set. A design that polls with the old value everywhere would take it on the set-disable that should cancel it. A design that delays repeated clears would miss the second one. The break window is probed at cycles 2 and 6. A wrong window bound either drops a late non-maskable request into the redirect, or leaves an early one pending, which gives a second entry. Holding `nmi_n` low across several boundaries exposes a latch that follows the level instead of the edge.

// File: rtl/irq_poll_pkg.sv
package irq_poll_pkg;
  typedef enum logic [1:0] {
    KIND_NONE  = 2'd0,
    KIND_RESET = 2'd1,
    KIND_NMI   = 2'd2,
    KIND_IRQ   = 2'd3
  } kind_e;

  typedef enum logic [1:0] {
    OPC_OTHER = 2'd0,
    OPC_CLR   = 2'd1,
    OPC_SET   = 2'd2,
    OPC_PULL  = 2'd3
  } opcls_e;
endpackage

// File: rtl/irq_poll_nmi_latch.sv
module irq_poll_nmi_latch (
  input  logic clk,
  input  logic rst,
  input  logic nmi_n,
  input  logic clr,
  output logic pend_now
);
  logic line_q;
  logic pend_q;
  logic fall;

  assign fall     = line_q & ~nmi_n;
  assign pend_now = pend_q | fall;

  always_ff @(posedge clk) begin
    if (rst) begin
      line_q <= 1'b1;
      pend_q <= 1'b0;
    end else begin
      line_q <= nmi_n;
      pend_q <= pend_now & ~clr;
    end
  end
endmodule

// File: rtl/irq_poll_mask.sv
module irq_poll_mask
  import irq_poll_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cmos_mode,
  input  logic       boundary,
  input  logic [1:0] op_class,
  input  logic       i_flag,
  output logic       mask_eff
);
  logic before_q;
  logic wait_q;
  logic is_clr_like;
  logic is_set;

  assign is_clr_like = (op_class == OPC_CLR) || (op_class == OPC_PULL);
  assign is_set      = (op_class == OPC_SET);

  always_comb begin
    if (cmos_mode) begin
      mask_eff = is_set ? before_q : i_flag;
    end else if (is_set && wait_q) begin
      mask_eff = 1'b1;
    end else if (is_set || is_clr_like) begin
      mask_eff = before_q;
    end else begin
      mask_eff = i_flag;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      before_q <= 1'b1;
      wait_q   <= 1'b0;
    end else if (boundary) begin
      before_q <= i_flag;
      wait_q   <= ~cmos_mode & is_clr_like & before_q & ~i_flag;
    end
  end
endmodule

// File: rtl/irq_poll_brk.sv
module irq_poll_brk #(
  parameter int CNT_W       = 3,
  parameter int HIJACK_LAST = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmos_mode,
  input  logic [CNT_W-1:0] brk_cycle,
  input  logic             nmi_now,
  output logic             hijack,
  output logic             vec_nmi
);
  localparam logic [CNT_W-1:0] LAST_C = CNT_W'(HIJACK_LAST);
  logic in_window;

  assign in_window = (brk_cycle != '0) && (brk_cycle <= LAST_C);
  assign hijack    = ~cmos_mode & nmi_now & in_window;

  always_ff @(posedge clk) begin
    if (rst) begin
      vec_nmi <= 1'b0;
    end else if (brk_cycle == '0) begin
      vec_nmi <= 1'b0;
    end else if (hijack) begin
      vec_nmi <= 1'b1;
    end
  end
endmodule

// File: rtl/irq_poll_unit.sv
module irq_poll_unit
  import irq_poll_pkg::*;
#(
  parameter int BRK_CNT_W   = 3,
  parameter int HIJACK_LAST = 5
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cmos_mode,
  input  logic                 reset_req,
  input  logic                 nmi_n,
  input  logic                 irq_n,
  input  logic                 i_flag,
  input  logic                 boundary,
  input  logic [1:0]           op_class,
  input  logic [BRK_CNT_W-1:0] brk_cycle,
  output logic                 take_int,
  output logic [1:0]           kind,
  output logic                 vec_nmi
);
  logic  nmi_now;
  logic  nmi_clr;
  logic  mask_eff;
  logic  hijack;
  logic  res_q;
  logic  res_now;
  kind_e pick;

  irq_poll_nmi_latch u_nmi (
    .clk(clk), .rst(rst), .nmi_n(nmi_n), .clr(nmi_clr), .pend_now(nmi_now)
  );

  irq_poll_mask u_mask (
    .clk(clk), .rst(rst), .cmos_mode(cmos_mode), .boundary(boundary),
    .op_class(op_class), .i_flag(i_flag), .mask_eff(mask_eff)
  );

  irq_poll_brk #(.CNT_W(BRK_CNT_W), .HIJACK_LAST(HIJACK_LAST)) u_brk (
    .clk(clk), .rst(rst), .cmos_mode(cmos_mode), .brk_cycle(brk_cycle),
    .nmi_now(nmi_now), .hijack(hijack), .vec_nmi(vec_nmi)
  );

  assign res_now = res_q | reset_req;

  always_comb begin
    pick = KIND_NONE;
    if (boundary) begin
      if (res_now)                  pick = KIND_RESET;
      else if (nmi_now)             pick = KIND_NMI;
      else if (!irq_n && !mask_eff) pick = KIND_IRQ;
    end
  end

  assign nmi_clr = hijack | (pick == KIND_NMI);

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q    <= 1'b0;
      take_int <= 1'b0;
      kind     <= KIND_NONE;
    end else begin
      res_q    <= res_now & (pick != KIND_RESET);
      take_int <= (pick != KIND_NONE);
      kind     <= pick;
    end
  end
endmodule

// File: rtl/irq_poll_unit_chk.sv
module irq_poll_unit_chk (
  input logic       clk,
  input logic       rst,
  input logic       cmos_mode,
  input logic       reset_req,
  input logic       irq_n,
  input logic       i_flag,
  input logic       boundary,
  input logic [1:0] op_class,
  input logic       nmi_now,
  input logic       take_int,
  input logic [1:0] kind,
  input logic       vec_nmi
);
  // R1: an entry only follows a boundary strobe
  p_take_after_boundary_r1: assert property (@(posedge clk) disable iff (rst)
    take_int |-> $past(boundary));

  // R1: reset request beats everything
  p_reset_first_r1: assert property (@(posedge clk) disable iff (rst)
    boundary && reset_req |=> take_int && kind == 2'd1);

  // R3: flag set, other class, nothing else pending -> no entry
  p_masked_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    boundary && !reset_req && !nmi_now && op_class == 2'd0 && i_flag |=> !take_int);

  // R9: newer set takes the request on the clearing instruction itself
  p_cmos_immediate_r9: assert property (@(posedge clk) disable iff (rst)
    cmos_mode && boundary && op_class == 2'd1 && !i_flag && !irq_n |=> take_int);

  // R12: the redirect never rises in the newer set
  p_no_redirect_cmos_r12: assert property (@(posedge clk) disable iff (rst)
    $rose(vec_nmi) |-> !$past(cmos_mode));
endmodule

bind irq_poll_unit irq_poll_unit_chk u_chk (
  .clk(clk), .rst(rst), .cmos_mode(cmos_mode), .reset_req(reset_req),
  .irq_n(irq_n), .i_flag(i_flag), .boundary(boundary), .op_class(op_class),
  .nmi_now(nmi_now), .take_int(take_int), .kind(kind), .vec_nmi(vec_nmi)
);

// File: tb/irq_poll_unit_tb_top.sv
`timescale 1ns/1ps
module irq_poll_unit_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmos_mode = 1'b0;
  logic       reset_req = 1'b0;
  logic       nmi_n = 1'b1;
  logic       irq_n = 1'b1;
  logic       i_flag = 1'b1;
  logic       boundary = 1'b0;
  logic [1:0] op_class = 2'd0;
  logic [2:0] brk_cycle = 3'd0;
  logic       take_int;
  logic [1:0] kind;
  logic       vec_nmi;

  int tests = 0;
  int fails = 0;
  int ticks = 0;
  string cur_req = "R1";

  always #5 clk = ~clk;

  irq_poll_unit dut_i (
    .clk(clk), .rst(rst), .cmos_mode(cmos_mode), .reset_req(reset_req),
    .nmi_n(nmi_n), .irq_n(irq_n), .i_flag(i_flag), .boundary(boundary),
    .op_class(op_class), .brk_cycle(brk_cycle), .take_int(take_int),
    .kind(kind), .vec_nmi(vec_nmi)
  );

  // behavioural reference: expected registered outputs after each edge
  int m_kind = 0;
  bit m_vec = 0;
  bit m_line = 1, m_nmi = 0, m_res = 0, m_old_i = 1, m_cancel = 0;
  always @(posedge clk) begin
    if (rst) begin
      m_kind = 0; m_vec = 0; m_line = 1; m_nmi = 0; m_res = 0;
      m_old_i = 1; m_cancel = 0;
    end else begin
      bit nmi_seen, irq_ok, masked, early;
      nmi_seen = m_nmi || (m_line && !nmi_n);
      m_line = nmi_n;
      m_res = m_res || reset_req;
      early = brk_cycle >= 1 && brk_cycle <= 5;
      if (brk_cycle == 0) m_vec = 0;
      else if (!cmos_mode && early && nmi_seen) begin m_vec = 1; nmi_seen = 0; end
      case (op_class)
        2'd0: masked = i_flag;
        2'd2: masked = (!cmos_mode && m_cancel) ? 1'b1 : m_old_i;
        default: masked = cmos_mode ? i_flag : m_old_i;
      endcase
      irq_ok = !irq_n && !masked;
      m_kind = 0;
      if (boundary) begin
        if (m_res) begin m_kind = 1; m_res = 0; end
        else if (nmi_seen) begin m_kind = 2; nmi_seen = 0; end
        else if (irq_ok) m_kind = 3;
        m_cancel = !cmos_mode && (op_class == 2'd1 || op_class == 2'd3) && m_old_i && !i_flag;
        m_old_i = i_flag;
      end
      m_nmi = nmi_seen;
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // one clock; compare DUT against the model after the edge
  task automatic cyc();
    @(posedge clk);
    #2;
    if (!rst) begin
      tests++;
      if (take_int !== (m_kind != 0) || kind !== 2'(m_kind) || vec_nmi !== m_vec) begin
        fails++;
        $display("FAIL %s model take/kind/vec actual=%0d/%0d/%0d expected=%0d/%0d/%0d",
                 cur_req, take_int, kind, vec_nmi, m_kind != 0, m_kind, m_vec);
      end
    end
  endtask

  task automatic bnd(input logic [1:0] op, input logic fl);
    boundary = 1'b1; op_class = op; i_flag = fl;
    cyc();
    boundary = 1'b0; op_class = 2'd0;
  endtask

  task automatic idle_sync(input logic mode);
    irq_n = 1'b1; nmi_n = 1'b1; cmos_mode = mode;
    cyc();
    bnd(2'd0, 1'b1);
  endtask

  initial begin
    cyc(); cyc();
    rst = 1'b0;
    cur_req = "R1";
    chk("R1", "reset take", take_int, 0);
    chk("R1", "reset kind", kind, 0);
    cyc();

    // R3 masked / unmasked level request
    cur_req = "R3"; idle_sync(0);
    irq_n = 1'b0;
    bnd(2'd0, 1'b1); chk("R3", "masked take", take_int, 0);
    bnd(2'd0, 1'b0); chk("R3", "unmasked kind", kind, 3);
    bnd(2'd0, 1'b0); chk("R3", "level repeat kind", kind, 3);

    // R1 / R2 priority and reset memory
    cur_req = "R2"; idle_sync(0);
    reset_req = 1'b1; cyc(); reset_req = 1'b0; cyc(); cyc();
    irq_n = 1'b0; nmi_n = 1'b0; cyc();
    bnd(2'd0, 1'b0); chk("R2", "remembered reset kind", kind, 1);
    cur_req = "R1";
    bnd(2'd0, 1'b0); chk("R1", "nmi over irq kind", kind, 2);
    bnd(2'd0, 1'b0); chk("R1", "irq last kind", kind, 3);

    // R4 edge latch, one entry for a held line
    cur_req = "R4"; idle_sync(0);
    nmi_n = 1'b0; cyc(); cyc();
    bnd(2'd0, 1'b1); chk("R4", "nmi latched kind", kind, 2);
    bnd(2'd0, 1'b1); chk("R4", "held line no second entry", take_int, 0);
    nmi_n = 1'b1; cyc();

    // R5 older set clear-disable wait
    cur_req = "R5"; idle_sync(0);
    irq_n = 1'b0;
    bnd(2'd1, 1'b0); chk("R5", "no take on clear", take_int, 0);
    bnd(2'd0, 1'b0); chk("R5", "take one later", kind, 3);

    // R6 clear then set cancels
    cur_req = "R6"; idle_sync(0);
    irq_n = 1'b0;
    bnd(2'd1, 1'b0); chk("R6", "no take on clear", take_int, 0);
    bnd(2'd2, 1'b1); chk("R6", "set cancels", take_int, 0);
    bnd(2'd0, 1'b1); chk("R6", "still none", take_int, 0);

    // R7 two clears
    cur_req = "R7"; idle_sync(0);
    irq_n = 1'b0;
    bnd(2'd1, 1'b0); chk("R7", "first clear none", take_int, 0);
    bnd(2'd1, 1'b0); chk("R7", "second clear takes", kind, 3);

    // R8 flag pull rules
    cur_req = "R8"; idle_sync(0);
    irq_n = 1'b0;
    bnd(2'd3, 1'b0); chk("R8", "pull no take", take_int, 0);
    bnd(2'd0, 1'b0); chk("R8", "pull then take", kind, 3);
    idle_sync(0); irq_n = 1'b0;
    bnd(2'd3, 1'b0); bnd(2'd2, 1'b1); chk("R8", "pull then set cancels", take_int, 0);
    idle_sync(0); irq_n = 1'b0;
    bnd(2'd3, 1'b0); bnd(2'd3, 1'b0); chk("R8", "second pull takes", kind, 3);

    // R9 newer set immediate
    cur_req = "R9"; idle_sync(1);
    irq_n = 1'b0;
    bnd(2'd1, 1'b0); chk("R9", "clear takes at once", kind, 3);
    idle_sync(1); irq_n = 1'b0;
    bnd(2'd3, 1'b0); chk("R9", "pull takes at once", kind, 3);

    // R10 set-disable still interruptible
    cur_req = "R10";
    for (int md = 0; md < 2; md++) begin
      idle_sync(md[0]);
      bnd(2'd0, 1'b0);
      irq_n = 1'b0;
      bnd(2'd2, 1'b1); chk("R10", "set still takes", kind, 3);
    end

    // R11 older set break redirect window
    cur_req = "R11"; idle_sync(0);
    brk_cycle = 3'd1; cyc();
    brk_cycle = 3'd2; nmi_n = 1'b0; cyc();
    chk("R11", "redirect set", vec_nmi, 1);
    for (int c = 3; c <= 7; c++) begin brk_cycle = 3'(c); cyc(); end
    chk("R11", "redirect held", vec_nmi, 1);
    brk_cycle = 3'd0; cyc();
    chk("R11", "redirect cleared", vec_nmi, 0);
    bnd(2'd0, 1'b1); chk("R11", "consumed nmi", take_int, 0);
    nmi_n = 1'b1; cyc();
    brk_cycle = 3'd6; nmi_n = 1'b0; cyc();
    chk("R11", "late nmi no redirect", vec_nmi, 0);
    brk_cycle = 3'd7; cyc(); brk_cycle = 3'd0;
    bnd(2'd0, 1'b1); chk("R11", "late nmi taken", kind, 2);

    // R12 newer set holds nmi through break
    cur_req = "R12"; idle_sync(1);
    brk_cycle = 3'd2; nmi_n = 1'b0; cyc();
    chk("R12", "no redirect", vec_nmi, 0);
    for (int c = 3; c <= 7; c++) begin brk_cycle = 3'(c); cyc(); end
    brk_cycle = 3'd0;
    bnd(2'd0, 1'b1); chk("R12", "nmi after break", kind, 2);
    nmi_n = 1'b1; cyc();

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  always @(posedge clk) begin
    ticks++;
    if (ticks > 20000) begin
      tests++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", ticks, 20000);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule